// File: doc/BRIEF.md
# Programmable three-port parallel interface

This block is a CPU-facing parallel I/O peripheral. It has two 8-bit data ports (A and B) and an 8-bit control/status port (C), plus a control register. A 2-bit address selects one of the four. A mode byte written to the control register sets the direction of port A, port B and each half of port C. It also picks, separately for group A (port A plus the upper half of port C) and group B (port B plus the lower half), between a plain latched mode and a strobed handshake mode.

In the plain mode, every port is either an output latch or a direct input. In the strobed mode, port A and port B each get one handshake line in from the peripheral. For an input port this line is a strobe; for an output port it is an acknowledge. Each port also gets a buffer-full flag and a gated interrupt request. These lines take over fixed bits of port C, and reading port C then returns the handshake status in place of those bits.

A control write with bit 7 clear is a single-bit set/reset command on port C. In the strobed mode, this command also writes the interrupt enables.

Top module: `ppi3_core`

## Requirements
- R1: After reset the control register reads 8'h9B. All output latches are 0. The output enables `pa_oe`, `pb_oe` and `pc_oe` are 0. Both interrupt requests are low.
- R2: Address 0, 1, 2 and 3 select port A, port B, port C and the control register, for both reads and writes. A control write with bit 7 set stores the mode byte, and reading address 3 then returns that byte.
- R3: In the mode byte, a bit value of 1 means input for four direction bits: bit 4 (port A), bit 3 (port C bits 7:4), bit 1 (port B) and bit 0 (port C bits 3:0). `pa_oe`, `pb_oe` and the bits of `pc_oe` that are not handshake lines are high exactly for the output-directed ports and bits.
- R4: In mode 0, reading an input port returns its pins, and reading an output port returns its latch. A write to an input-directed port A or B is ignored: its latch, and therefore its `*_out` value, stays unchanged.
- R5: A write to port C updates only the bits that are output-directed and are not handshake lines. All other latch bits keep their value.
- R6: A control write with bit 7 = 0 sets port C bit wdata[3:1] to wdata[0]. It is subject to the same per-bit write mask as R5, so it has no effect on input-directed bits.
- R7: Any mode-byte write clears the A, B and C output latches, both buffer-full flags, both interrupt enables and both interrupt requests.
- R8: In mode 1 input, a low handshake line latches the port pins and sets the input-buffer-full flag. For port A the strobe is pc_in[4] and the flag is pc_out[5]; for port B they are pc_in[2] and pc_out[1]. A later read of the port returns the latched data.
- R9: In mode 1 input, the interrupt request equals input-buffer-full AND interrupt-enable AND strobe high. A CPU read of the port clears the buffer-full flag, and with it the request, on that clock edge.
- R10: In mode 1 output, a CPU write to the port sets output-buffer-full and clears the request. Output-buffer-full is active low on the pin: pc_out[7] for A, pc_out[1] for B. A low acknowledge clears output-buffer-full (pc_in[6] for A, pc_in[2] for B). When the acknowledge returns high with the interrupt enable set, the request is raised.
- R11: In mode 1 the interrupt enables are written through the bit set/reset command. The A enable is bit 4 when port A is an input and bit 6 when it is an output; the B enable is bit 2. Reading port C returns status in place of the handshake bits:
  - bit 3: A request; bit 0: B request.
  - bit 5: A input-buffer-full, or bit 7: A output-buffer-full in its active-low form.
  - bit 4 or 6: the A enable.
  - bit 1: B buffer-full flag (output form active low); bit 2: the B enable.
- R12: The A and B requests drive pc_out[3] and pc_out[0] as well as `irq_a` and `irq_b`. `irq_a_chg` and `irq_b_chg` are high for exactly the one cycle after each change of their request.
- R13: A group A mode field of 2'b1x is handled as mode 1 (default `MODE2_AS_MODE1` = 1).
- R14: In mode 1, the port C bits that are strobe or acknowledge inputs have output enable 0, and the bits that carry flags or requests have output enable 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | CPU write strobe, one cycle |
| rd_en | input | 1 | CPU read strobe, one cycle (clears input-buffer-full) |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, combinational on addr |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pins in (also strobe/acknowledge lines) |
| pc_out | output | 8 | Port C output values including handshake outputs |
| pc_oe | output | 8 | Port C per-bit output enable |
| irq_a | output | 1 | Group A interrupt request |
| irq_b | output | 1 | Group B interrupt request |
| irq_a_chg | output | 1 | One-cycle pulse after irq_a changes |
| irq_b_chg | output | 1 | One-cycle pulse after irq_b changes |

## Verification
Most internal state of this block is visible at the ports within a single clock. A stale mode byte shows at once in the output enables and in the control readback. A lost or stuck buffer-full flag shows on its port C pin on the cycle after the strobe, acknowledge or CPU access that should have moved it. A wrong write mask shows up as port C bits that change when they should hold, which the bench catches by sweeping all sixteen direction combinations. An interrupt gating error appears as a request, or a change pulse, that is present or missing on the cycle after the strobe or acknowledge returns high.

// File: rtl/ppi3_pkg.sv
package ppi3_pkg;
   // port C bit positions owned by the strobed handshakes
   localparam int PC_IRQ_A  = 3;
   localparam int PC_STB_A  = 4;
   localparam int PC_IBF_A  = 5;
   localparam int PC_ACK_A  = 6;
   localparam int PC_OBF_A  = 7;
   localparam int PC_IRQ_B  = 0;
   localparam int PC_FLG_B  = 1;
   localparam int PC_HS_B   = 2;
   localparam int PORT_W    = 8;

   typedef struct packed {
      logic a_m1;
      logic a_in;
      logic cu_in;
      logic b_m1;
      logic b_in;
      logic cl_in;
   } ppi3_cfg_t;
endpackage

// File: rtl/ppi3_sync.sv
module ppi3_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         logic unused_pins;
         assign unused_pins = clk ^ rst_n;
         assign q = d;
      end else begin : g_reg
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ppi3_hs_chan.sv
module ppi3_hs_chan #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          mode1,
   input  logic          is_input,
   input  logic          hs_n,
   input  logic          cpu_rd,
   input  logic          cpu_wr,
   input  logic          inte_we,
   input  logic          inte_d,
   input  logic [DW-1:0] pins,
   output logic [DW-1:0] in_data,
   output logic          ibf,
   output logic          obf,
   output logic          inte,
   output logic          irq,
   output logic          irq_chg
);
   logic hs_q;
   logic irq_o;
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hs_q    <= 1'b1;
         irq_q   <= 1'b0;
         irq_o   <= 1'b0;
         ibf     <= 1'b0;
         obf     <= 1'b0;
         inte    <= 1'b0;
         in_data <= '0;
      end else begin
         hs_q  <= hs_n;
         irq_q <= irq;
         if (inte_we) inte <= inte_d;
         if (clr) begin
            ibf   <= 1'b0;
            obf   <= 1'b0;
            inte  <= 1'b0;
            irq_o <= 1'b0;
         end else if (mode1) begin
            if (is_input) begin
               if (!hs_n) begin
                  ibf     <= 1'b1;
                  in_data <= pins;
               end else if (cpu_rd) begin
                  ibf <= 1'b0;
               end
            end else begin
               if (cpu_wr) begin
                  obf   <= 1'b1;
                  irq_o <= 1'b0;
               end else begin
                  if (!hs_n) obf <= 1'b0;
                  if (hs_n && !hs_q && inte) irq_o <= 1'b1;
               end
            end
         end
      end
   end

   assign irq     = mode1 & (is_input ? (ibf & inte & hs_q) : irq_o);
   assign irq_chg = irq ^ irq_q;
endmodule

// File: rtl/ppi3_portc.sv
module ppi3_portc
   import ppi3_pkg::*;
(
   input  ppi3_cfg_t   cfg,
   input  logic [7:0]  pc_lat,
   input  logic [7:0]  pc_in,
   input  logic        irq_a,
   input  logic        ibf_a,
   input  logic        obf_a,
   input  logic        inte_a,
   input  logic        irq_b,
   input  logic        ibf_b,
   input  logic        obf_b,
   input  logic        inte_b,
   output logic [7:0]  pc_out,
   output logic [7:0]  pc_oe,
   output logic [7:0]  pc_rd,
   output logic [7:0]  wmask
);
   logic [7:0] dir;
   logic [7:0] hs;
   logic [7:0] hs_val;
   logic [7:0] hs_oe;
   logic [7:0] hs_st;

   always_comb begin
      dir    = {{4{~cfg.cu_in}}, {4{~cfg.cl_in}}};
      hs     = '0;
      hs_val = '0;
      hs_oe  = '0;
      hs_st  = '0;
      if (cfg.a_m1) begin
         hs[PC_IRQ_A]     = 1'b1;
         hs_val[PC_IRQ_A] = irq_a;
         hs_oe[PC_IRQ_A]  = 1'b1;
         hs_st[PC_IRQ_A]  = irq_a;
         if (cfg.a_in) begin
            hs[PC_STB_A]     = 1'b1;
            hs_st[PC_STB_A]  = inte_a;
            hs[PC_IBF_A]     = 1'b1;
            hs_val[PC_IBF_A] = ibf_a;
            hs_oe[PC_IBF_A]  = 1'b1;
            hs_st[PC_IBF_A]  = ibf_a;
         end else begin
            hs[PC_ACK_A]     = 1'b1;
            hs_st[PC_ACK_A]  = inte_a;
            hs[PC_OBF_A]     = 1'b1;
            hs_val[PC_OBF_A] = ~obf_a;
            hs_oe[PC_OBF_A]  = 1'b1;
            hs_st[PC_OBF_A]  = ~obf_a;
         end
      end
      if (cfg.b_m1) begin
         hs[PC_IRQ_B]     = 1'b1;
         hs_val[PC_IRQ_B] = irq_b;
         hs_oe[PC_IRQ_B]  = 1'b1;
         hs_st[PC_IRQ_B]  = irq_b;
         hs[PC_FLG_B]     = 1'b1;
         hs_val[PC_FLG_B] = cfg.b_in ? ibf_b : ~obf_b;
         hs_oe[PC_FLG_B]  = 1'b1;
         hs_st[PC_FLG_B]  = cfg.b_in ? ibf_b : ~obf_b;
         hs[PC_HS_B]      = 1'b1;
         hs_st[PC_HS_B]   = inte_b;
      end
      wmask  = dir & ~hs;
      pc_oe  = (dir & ~hs) | hs_oe;
      pc_out = (pc_lat & ~hs) | hs_val;
      pc_rd  = (hs & hs_st) | (~hs & dir & pc_lat) | (~hs & ~dir & pc_in);
   end
endmodule

// File: rtl/ppi3_core.sv
module ppi3_core
   import ppi3_pkg::*;
#(
   parameter logic [7:0] MODE_RESET     = 8'h9B,
   parameter bit         MODE2_AS_MODE1 = 1'b1,
   parameter int         HS_SYNC        = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  addr,
   input  logic        wr_en,
   input  logic        rd_en,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   input  logic [7:0]  pa_in,
   output logic [7:0]  pa_out,
   output logic        pa_oe,
   input  logic [7:0]  pb_in,
   output logic [7:0]  pb_out,
   output logic        pb_oe,
   input  logic [7:0]  pc_in,
   output logic [7:0]  pc_out,
   output logic [7:0]  pc_oe,
   output logic        irq_a,
   output logic        irq_b,
   output logic        irq_a_chg,
   output logic        irq_b_chg
);
   localparam logic [2:0] SEL_INTE_AI = 3'(PC_STB_A);
   localparam logic [2:0] SEL_INTE_AO = 3'(PC_ACK_A);
   localparam logic [2:0] SEL_INTE_B  = 3'(PC_HS_B);

   initial begin
      assert (MODE_RESET[7]) else $error("MODE_RESET must have bit 7 set");
      assert (HS_SYNC >= 0 && HS_SYNC <= 4) else $error("HS_SYNC out of range");
   end

   logic [7:0] mode_q;
   logic [7:0] pa_lat, pb_lat, pc_lat;
   logic       a_m1;
   ppi3_cfg_t  cfg;
   logic [7:0] wmask, pc_rd;
   logic [7:0] a_data, b_data;
   logic       ibf_a, obf_a, inte_a, ibf_b, obf_b, inte_b;
   logic       hs_a_raw, hs_a_n, hs_b_n;

   generate
      if (MODE2_AS_MODE1) begin : g_m2_hs
         assign a_m1 = mode_q[6] | mode_q[5];
      end else begin : g_m2_plain
         assign a_m1 = (mode_q[6:5] == 2'b01);
      end
   endgenerate

   assign cfg = {a_m1, mode_q[4], mode_q[3], mode_q[2], mode_q[1], mode_q[0]};

   logic       mode_we, bsr_we;
   logic [2:0] bsr_sel;
   assign mode_we = wr_en && (addr == 2'd3) &&  wdata[7];
   assign bsr_we  = wr_en && (addr == 2'd3) && !wdata[7];
   assign bsr_sel = wdata[3:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         pa_lat <= '0;
         pb_lat <= '0;
         pc_lat <= '0;
      end else if (mode_we) begin
         mode_q <= wdata;
         pa_lat <= '0;
         pb_lat <= '0;
         pc_lat <= '0;
      end else begin
         if (wr_en && addr == 2'd0 && !cfg.a_in) pa_lat <= wdata;
         if (wr_en && addr == 2'd1 && !cfg.b_in) pb_lat <= wdata;
         if (wr_en && addr == 2'd2) pc_lat <= (pc_lat & ~wmask) | (wdata & wmask);
         if (bsr_we && wmask[bsr_sel]) pc_lat[bsr_sel] <= wdata[0];
      end
   end

   assign hs_a_raw = cfg.a_in ? pc_in[PC_STB_A] : pc_in[PC_ACK_A];

   ppi3_sync #(.STAGES(HS_SYNC)) u_sync_a (.clk(clk), .rst_n(rst_n), .d(hs_a_raw), .q(hs_a_n));
   ppi3_sync #(.STAGES(HS_SYNC)) u_sync_b (.clk(clk), .rst_n(rst_n), .d(pc_in[PC_HS_B]), .q(hs_b_n));

   ppi3_hs_chan #(.DW(PORT_W)) u_chan_a (
      .clk(clk), .rst_n(rst_n), .clr(mode_we), .mode1(cfg.a_m1), .is_input(cfg.a_in),
      .hs_n(hs_a_n), .cpu_rd(rd_en && addr == 2'd0), .cpu_wr(wr_en && addr == 2'd0),
      .inte_we(bsr_we && cfg.a_m1 && bsr_sel == (cfg.a_in ? SEL_INTE_AI : SEL_INTE_AO)),
      .inte_d(wdata[0]), .pins(pa_in), .in_data(a_data), .ibf(ibf_a), .obf(obf_a),
      .inte(inte_a), .irq(irq_a), .irq_chg(irq_a_chg));

   ppi3_hs_chan #(.DW(PORT_W)) u_chan_b (
      .clk(clk), .rst_n(rst_n), .clr(mode_we), .mode1(cfg.b_m1), .is_input(cfg.b_in),
      .hs_n(hs_b_n), .cpu_rd(rd_en && addr == 2'd1), .cpu_wr(wr_en && addr == 2'd1),
      .inte_we(bsr_we && cfg.b_m1 && bsr_sel == SEL_INTE_B),
      .inte_d(wdata[0]), .pins(pb_in), .in_data(b_data), .ibf(ibf_b), .obf(obf_b),
      .inte(inte_b), .irq(irq_b), .irq_chg(irq_b_chg));

   ppi3_portc u_portc (
      .cfg(cfg), .pc_lat(pc_lat), .pc_in(pc_in),
      .irq_a(irq_a), .ibf_a(ibf_a), .obf_a(obf_a), .inte_a(inte_a),
      .irq_b(irq_b), .ibf_b(ibf_b), .obf_b(obf_b), .inte_b(inte_b),
      .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd), .wmask(wmask));

   always_comb begin
      case (addr)
         2'd0:    rdata = cfg.a_in ? (cfg.a_m1 ? a_data : pa_in) : pa_lat;
         2'd1:    rdata = cfg.b_in ? (cfg.b_m1 ? b_data : pb_in) : pb_lat;
         2'd2:    rdata = pc_rd;
         default: rdata = mode_q;
      endcase
   end

   assign pa_out = pa_lat;
   assign pb_out = pb_lat;
   assign pa_oe  = ~cfg.a_in;
   assign pb_oe  = ~cfg.b_in;
endmodule

// File: rtl/ppi3_core_chk.sv
module ppi3_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] addr,
   input logic       wr_en,
   input logic       rd_en,
   input logic [7:0] wdata,
   input logic [7:0] pa_out,
   input logic [7:0] pb_out,
   input logic [7:0] pc_out,
   input logic       irq_a,
   input logic       irq_b,
   input logic       irq_a_chg,
   input logic [7:0] mode_q,
   input logic       a_m1,
   input logic       hs_a_n
);
   logic ctl_wr;
   assign ctl_wr = wr_en && (addr == 2'd3);

   // R8
   ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_m1 && mode_q[4] && !hs_a_n && !ctl_wr) |=> pc_out[5]);

   // R9
   rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_m1 && mode_q[4] && hs_a_n && rd_en && addr == 2'd0 && !ctl_wr) |=> (!pc_out[5] && !irq_a));

   // R10
   obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_m1 && !mode_q[4] && wr_en && addr == 2'd0) |=> (!pc_out[7] && !irq_a));

   // R7
   mode_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[7]) |=> (pa_out == 8'h00 && pb_out == 8'h00 && !irq_a && !irq_b));

   // R2
   mode_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[7]) |=> (mode_q == $past(wdata)));

   // R12
   irq_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_a != $past(irq_a)) |-> irq_a_chg);
endmodule

bind ppi3_core ppi3_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
   .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out), .irq_a(irq_a), .irq_b(irq_b),
   .irq_a_chg(irq_a_chg), .mode_q(mode_q), .a_m1(a_m1), .hs_a_n(hs_a_n));

// File: tb/ppi3_core_bench.sv
module ppi3_core_bench;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] addr;
   logic       wr_en, rd_en;
   logic [7:0] wdata, rdata;
   logic [7:0] pa_in, pa_out, pb_in, pb_out, pc_in, pc_out, pc_oe;
   logic       pa_oe, pb_oe, irq_a, irq_b, irq_a_chg, irq_b_chg;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ppi3_core u_ppi3_core (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .pc_in(pc_in), .pc_out(pc_out),
      .pc_oe(pc_oe), .irq_a(irq_a), .irq_b(irq_b), .irq_a_chg(irq_a_chg),
      .irq_b_chg(irq_b_chg));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 100000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] v, mb, da, db, dc, dir, expc;
      rst_n = 1'b0; addr = 2'd0; wr_en = 1'b0; rd_en = 1'b0; wdata = 8'h00;
      pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd3, v);
      chk("R1 mode", 32'(v), 32'h9B);
      chk("R1 oe", {pa_oe, pb_oe, pc_oe}, 10'h000);
      chk("R1 latches", {pa_out, pb_out}, 16'h0000);
      chk("R1 irq", {irq_a, irq_b}, 2'b00);

      // R2 R3 R4 R5 R7: sweep all mode-0 direction combinations
      for (int m = 0; m < 16; m++) begin
         mb  = 8'h80 | (8'(m & 1) << 4) | (8'((m >> 1) & 1) << 3)
                     | (8'((m >> 2) & 1) << 1) | 8'((m >> 3) & 1);
         dir = {{4{~mb[3]}}, {4{~mb[0]}}};
         wr(2'd3, mb);
         chk("R7 clear", {pa_out, pb_out, pc_out}, 24'h0);
         rd(2'd3, v);
         chk("R2 readback", 32'(v), 32'(mb));
         chk("R3 oe", {pa_oe, pb_oe, pc_oe}, {~mb[4], ~mb[1], dir});
         pa_in = 8'h5A ^ 8'(m);
         pb_in = 8'hC3 + 8'(m);
         pc_in = 8'h96 ^ 8'(m * 17);
         da = 8'hA5 ^ 8'(m * 3);
         db = 8'h3C + 8'(m * 5);
         dc = 8'hE1 ^ 8'(m * 9);
         wr(2'd0, da);
         wr(2'd1, db);
         wr(2'd2, dc);
         chk("R4 pa_out", 32'(pa_out), mb[4] ? 32'h0 : 32'(da));
         chk("R4 pb_out", 32'(pb_out), mb[1] ? 32'h0 : 32'(db));
         rd(2'd0, v);
         chk("R4 read A", 32'(v), mb[4] ? 32'(pa_in) : 32'(da));
         rd(2'd1, v);
         chk("R4 read B", 32'(v), mb[1] ? 32'(pb_in) : 32'(db));
         chk("R5 pc_out", 32'(pc_out), 32'(dc & dir));
         rd(2'd2, v);
         chk("R5 read C", 32'(v), 32'((dc & dir) | (pc_in & ~dir)));
      end

      // R6 bit set/reset with lower half input
      pc_in = 8'h00;
      wr(2'd3, 8'h81);
      expc = 8'h00;
      for (int b = 0; b < 8; b++) begin
         wr(2'd3, 8'((b << 1) | 1));
         if (b >= 4) expc[b] = 1'b1;
         chk("R6 set", 32'(pc_out), 32'(expc));
      end
      for (int b = 0; b < 8; b++) begin
         wr(2'd3, 8'(b << 1));
         if (b >= 4) expc[b] = 1'b0;
         chk("R6 reset", 32'(pc_out), 32'(expc));
      end

      // mode 1 port A input
      pc_in = 8'hFF;
      wr(2'd3, 8'hB0);
      chk("R14 oe A in", 32'(pc_oe), 32'hEF);
      pa_in = 8'h3C;
      @(negedge clk) pc_in[4] = 1'b0;
      @(negedge clk);
      chk("R8 ibf A", 32'(pc_out[5]), 32'h1);
      chk("R9 no inte", 32'(irq_a), 32'h0);
      pc_in[4] = 1'b1; pa_in = 8'h00;
      @(negedge clk);
      chk("R9 no inte hi", 32'(irq_a), 32'h0);
      rd(2'd0, v);
      chk("R8 data A", 32'(v), 32'h3C);
      chk("R9 ibf cleared", 32'(pc_out[5]), 32'h0);
      wr(2'd3, 8'h09);
      rd(2'd2, v);
      chk("R11 status inte", 32'(v), 32'h10);
      pa_in = 8'hE7;
      @(negedge clk) pc_in[4] = 1'b0;
      @(negedge clk);
      chk("R9 irq held by strobe", {pc_out[5], irq_a}, 2'b10);
      pc_in[4] = 1'b1;
      @(negedge clk);
      chk("R12 irq A", {irq_a, irq_a_chg, pc_out[3]}, 3'b111);
      @(negedge clk);
      chk("R12 pulse end", 32'(irq_a_chg), 32'h0);
      rd(2'd2, v);
      chk("R11 status full", 32'(v), 32'h38);
      rd(2'd0, v);
      chk("R8 data A2", 32'(v), 32'hE7);
      chk("R9 read clears", {irq_a, pc_out[5]}, 2'b00);
      chk("R12 fall pulse", 32'(irq_a_chg), 32'h1);
      @(negedge clk) pc_in[4] = 1'b0;
      @(negedge clk) pc_in[4] = 1'b1;
      @(negedge clk);
      chk("R9 irq again", 32'(irq_a), 32'h1);
      wr(2'd3, 8'hB0);
      chk("R7 flags clear", {irq_a, pc_out[5]}, 2'b00);

      // mode 1 port A output
      wr(2'd3, 8'hA0);
      chk("R14 oe A out", 32'(pc_oe), 32'hBF);
      wr(2'd2, 8'hFF);
      chk("R5 hs masked", 32'(pc_out), 32'hB7);
      wr(2'd3, 8'h0D);
      wr(2'd0, 8'h77);
      chk("R10 obf set", {pa_out, pc_out[7], irq_a}, {8'h77, 2'b00});
      rd(2'd2, v);
      chk("R11 status out", 32'(v), 32'h77 & 32'h37 | 32'h40);
      @(negedge clk) pc_in[6] = 1'b0;
      @(negedge clk);
      chk("R10 ack clears", {pc_out[7], irq_a}, 2'b10);
      pc_in[6] = 1'b1;
      @(negedge clk);
      chk("R10 irq on ack end", 32'(irq_a), 32'h1);
      wr(2'd0, 8'h12);
      chk("R10 write clears irq", {irq_a, pc_out[7]}, 2'b00);
      wr(2'd3, 8'h0C);
      @(negedge clk) pc_in[6] = 1'b0;
      @(negedge clk) pc_in[6] = 1'b1;
      @(negedge clk);
      chk("R10 no inte", {irq_a, pc_out[7]}, 2'b01);

      // mode 1 port B input
      wr(2'd3, 8'h86);
      wr(2'd3, 8'h05);
      pb_in = 8'h9D;
      @(negedge clk) pc_in[2] = 1'b0;
      @(negedge clk);
      chk("R8 ibf B", {pc_out[1], irq_b}, 2'b10);
      pc_in[2] = 1'b1;
      @(negedge clk);
      chk("R12 irq B", {irq_b, irq_b_chg, pc_out[0]}, 3'b111);
      rd(2'd1, v);
      chk("R8 data B", 32'(v), 32'h9D);
      chk("R9 B cleared", {irq_b, pc_out[1]}, 2'b00);

      // mode 1 port B output
      wr(2'd3, 8'h84);
      wr(2'd3, 8'h05);
      wr(2'd1, 8'h44);
      chk("R10 obf B", {pb_out, pc_out[1]}, {8'h44, 1'b0});
      @(negedge clk) pc_in[2] = 1'b0;
      @(negedge clk);
      chk("R10 ack B", 32'(pc_out[1]), 32'h1);
      pc_in[2] = 1'b1;
      @(negedge clk);
      chk("R10 irq B", 32'(irq_b), 32'h1);

      // R13 group A field 11 behaves as strobed mode
      wr(2'd3, 8'hC0);
      wr(2'd3, 8'h0D);
      wr(2'd0, 8'h21);
      chk("R13 obf", {pc_out[7], pc_oe[6]}, 2'b00);

      finish_run();
   end
endmodule